// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of up to 32 general-purpose pins controlled through a plain 32-bit register port. Every register holds one bit per pin. Software picks a role for each pin: general input, general output, or interrupt input. Pins in interrupt input mode are watched for a level or an edge. The polarity can be chosen, and both edges can be detected at once. Results collect in a per-pin pending view that software can read. The pending view, gated by a per-pin enable set, drives a single combined interrupt line.

Incoming pin levels pass through a two-stage synchroniser before anything else looks at them. The polarity register acts on both the interrupt detector and the input-data readback, so an inverted pin reads back inverted. Enables are managed through two write-only views. One disables the pins where a zero is written. The other enables the pins where a one is written. A read-modify-write is therefore never needed to change one pin.

The register port has no valid/ready handshake and no back-pressure. A write is taken in the cycle where `reg_wen` is high. Read data is a combinational function of `reg_addr`, valid in the same cycle.

Top module: `gpio_irq_bank`

## Requirements
- R1: Registers by byte offset: 0x00 mode (1 = interrupt input), 0x04 direction (1 = output), 0x08 output data, 0x24 edge select (1 = edge), 0x20 polarity (1 = low/falling), 0x28 filter enable, 0x4C both-edge, 0x18 reads the enable set. Written values read back unchanged. Offsets 0x0C and 0x10 are read-only, and writes to them have no effect. Offsets 0x14 and 0x1C, and every unmapped offset, read as zero.
- R2: Offset 0x0C reads each pin XOR its polarity bit, taken after a two-flop synchroniser. A pin change is visible after the second rising clock edge.
- R3: `pin_oe` bit n is 1 only when mode bit n is 0 and direction bit n is 1.
- R4: `pin_o` equals the output data register.
- R5: For a pin with mode 1 and edge select 0, pending bit n (offset 0x10) equals the synchronised pin XOR polarity. A pin with mode 0 never shows pending.
- R6: For a pin with mode 1, edge select 1 and both-edge 0, a rising edge (polarity 0) or a falling edge (polarity 1) sets a latched pending bit. The bit becomes visible after the third rising clock edge following the pin change. The opposite edge does not set it. The bit stays set when the pin returns.
- R7: With both-edge 1 on an edge pin, both a rising and a falling edge set the latched pending bit.
- R8: Writing 1 to bit n of offset 0x14 clears the latched pending bit n. Bits written as 0 leave their pending bits as they are.
- R9: A write to offset 0x18 disables every pin whose data bit is 0 and leaves the others unchanged. A write to offset 0x1C enables every pin whose data bit is 1 and leaves the others unchanged.
- R10: `irq_o` is 1 exactly when some pin has both its pending bit and its enable bit set.
- R11: After reset every register is zero: all pins are inputs, `pin_oe` is 0, nothing is enabled and `irq_o` is 0.
- R12: If an edge arrives in the same cycle as a clear write for that pin, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_i | input | NPINS | Pin levels from the pads |
| pin_o | output | NPINS | Pin drive values |
| pin_oe | output | NPINS | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Detecting an edge and clearing by write-one can fall on the same clock for the same pin. The bench provokes this by changing a both-edge pin and placing the clear write on the third rising edge after the change, the edge on which the detector latches. The pending bit must still read as set afterwards, and a later plain clear must remove it. That confirms the set had priority and that the clear path itself works.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int MAX_PINS = 32;
  localparam logic [7:0] OFF_MODE   = 8'h00;
  localparam logic [7:0] OFF_DIR    = 8'h04;
  localparam logic [7:0] OFF_DOUT   = 8'h08;
  localparam logic [7:0] OFF_DIN    = 8'h0C;
  localparam logic [7:0] OFF_PEND   = 8'h10;
  localparam logic [7:0] OFF_CLR    = 8'h14;
  localparam logic [7:0] OFF_MASK   = 8'h18;
  localparam logic [7:0] OFF_UNMASK = 8'h1C;
  localparam logic [7:0] OFF_POL    = 8'h20;
  localparam logic [7:0] OFF_EDGE   = 8'h24;
  localparam logic [7:0] OFF_FILT   = 8'h28;
  localparam logic [7:0] OFF_BOTH   = 8'h4C;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [NPINS-1:0]  mode_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  dout_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  edge_sel_o,
  output logic [NPINS-1:0]  both_o,
  output logic [NPINS-1:0]  filt_o,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  clr_o
);
  logic [NPINS-1:0] wbits;
  assign wbits = wdata[NPINS-1:0];

  function automatic logic hit(input logic [7:0] off);
    return wen && (addr == ADDR_W'(off));
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o     <= '0;
      dir_o      <= '0;
      dout_o     <= '0;
      pol_o      <= '0;
      edge_sel_o <= '0;
      both_o     <= '0;
      filt_o     <= '0;
      en_o       <= '0;
    end else begin
      if (hit(OFF_MODE))   mode_o     <= wbits;
      if (hit(OFF_DIR))    dir_o      <= wbits;
      if (hit(OFF_DOUT))   dout_o     <= wbits;
      if (hit(OFF_POL))    pol_o      <= wbits;
      if (hit(OFF_EDGE))   edge_sel_o <= wbits;
      if (hit(OFF_BOTH))   both_o     <= wbits;
      if (hit(OFF_FILT))   filt_o     <= wbits;
      if (hit(OFF_MASK))   en_o       <= en_o & wbits;
      if (hit(OFF_UNMASK)) en_o       <= en_o | wbits;
    end
  end

  assign clr_o = hit(OFF_CLR) ? wbits : '0;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] prev_o
);
  logic [NPINS-1:0] chain [0:STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k <= STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= pin_i;
      for (int k = 1; k <= STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign sync_o = chain[STAGES-1];
  assign prev_o = chain[STAGES];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] edge_sel_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] set_o,
  output logic [NPINS-1:0] latch_o,
  output logic [NPINS-1:0] pend_o
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic rise, fall, seen, edge_mode;
    assign rise      = sync_i[n] & ~prev_i[n];
    assign fall      = ~sync_i[n] & prev_i[n];
    assign seen      = both_i[n] ? (rise | fall) : (pol_i[n] ? fall : rise);
    assign edge_mode = mode_i[n] & edge_sel_i[n];
    assign set_o[n]  = edge_mode & seen;

    always_ff @(posedge clk) begin
      if (!rst_n || !edge_mode) latch_o[n] <= 1'b0;
      else if (set_o[n])        latch_o[n] <= 1'b1;
      else if (clr_i[n])        latch_o[n] <= 1'b0;
    end

    assign pend_o[n] = mode_i[n] &
                       (edge_sel_i[n] ? latch_o[n] : (sync_i[n] ^ pol_i[n]));
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_o
);
  logic [NPINS-1:0] mode_q, dir_q, dout_q, pol_q, edge_q, both_q, filt_q, en_q;
  logic [NPINS-1:0] clr_q, sync_q, prev_q, set_q, latch_q, pend_q;

  gpio_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .mode_o(mode_q), .dir_o(dir_q), .dout_o(dout_q), .pol_o(pol_q),
    .edge_sel_o(edge_q), .both_o(both_q), .filt_o(filt_q), .en_o(en_q),
    .clr_o(clr_q)
  );

  gpio_in_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sync_o(sync_q), .prev_o(prev_q)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_q), .prev_i(prev_q),
    .mode_i(mode_q), .edge_sel_i(edge_q), .pol_i(pol_q), .both_i(both_q),
    .clr_i(clr_q), .set_o(set_q), .latch_o(latch_q), .pend_o(pend_q)
  );

  function automatic logic [31:0] widen(input logic [NPINS-1:0] v);
    logic [31:0] r;
    r = '0;
    r[NPINS-1:0] = v;
    return r;
  endfunction

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(OFF_MODE): reg_rdata = widen(mode_q);
      ADDR_W'(OFF_DIR):  reg_rdata = widen(dir_q);
      ADDR_W'(OFF_DOUT): reg_rdata = widen(dout_q);
      ADDR_W'(OFF_DIN):  reg_rdata = widen(sync_q ^ pol_q);
      ADDR_W'(OFF_PEND): reg_rdata = widen(pend_q);
      ADDR_W'(OFF_MASK): reg_rdata = widen(en_q);
      ADDR_W'(OFF_POL):  reg_rdata = widen(pol_q);
      ADDR_W'(OFF_EDGE): reg_rdata = widen(edge_q);
      ADDR_W'(OFF_FILT): reg_rdata = widen(filt_q);
      ADDR_W'(OFF_BOTH): reg_rdata = widen(both_q);
      default:           reg_rdata = '0;
    endcase
  end

  assign pin_o  = dout_q;
  assign pin_oe = ~mode_q & dir_q;
  assign irq_o  = |(pend_q & en_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  edge_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  set_q,
  input logic [NPINS-1:0]  latch_q
);
  logic [NPINS-1:0] wbits;
  logic wr_mask, wr_unmask, wr_clr;
  assign wbits     = reg_wdata[NPINS-1:0];
  assign wr_mask   = reg_wen && reg_addr == ADDR_W'(OFF_MASK);
  assign wr_unmask = reg_wen && reg_addr == ADDR_W'(OFF_UNMASK);
  assign wr_clr    = reg_wen && reg_addr == ADDR_W'(OFF_CLR);

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> ((en_q & ~$past(wbits)) == '0));

  assert_unmask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((~en_q & $past(wbits)) == '0));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((latch_q & $past(wbits) & ~$past(set_q)) == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> (($past(latch_q) & ~latch_q & $past(mode_q & edge_q)) == '0));

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (set_q != '0) |=> ((latch_q & $past(set_q)) == $past(set_q)));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mode_q(mode_q), .edge_q(edge_q), .en_q(en_q),
  .set_q(set_q), .latch_q(latch_q)
);

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam int NPINS = 32;
  localparam int AW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wen = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NPINS-1:0] pin_i = '0;
  logic [NPINS-1:0] pin_o, pin_oe;
  logic irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.NPINS(NPINS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  // {mode, pol, pin, expected input data, expected pending} for pin 0, level sense
  localparam logic [4:0] VEC [6] = '{
    5'b10111, 5'b10000, 5'b11011, 5'b11100, 5'b00110, 5'b01100
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 oe", 32'(pin_oe), 32'h0);
    chk("R11 irq", 32'(irq_o), 32'h0);
    rd(8'h00, v); chk("R11 mode", v, 0);
    rd(8'h18, v); chk("R11 enable", v, 0);
    @(negedge clk); rst_n = 1'b1;

    wr(8'h1C, 32'h1);
    foreach (VEC[i]) begin
      wr(8'h00, {31'b0, VEC[i][4]});
      wr(8'h20, {31'b0, VEC[i][3]});
      @(negedge clk); pin_i[0] = VEC[i][2];
      settle();
      rd(8'h0C, v); chk("R2 input data", 32'(v[0]), 32'(VEC[i][1]));
      rd(8'h10, v); chk("R5 level pending", 32'(v[0]), 32'(VEC[i][0]));
      chk("R10 irq level", 32'(irq_o), 32'(VEC[i][0]));
    end
    wr(8'h20, 0); wr(8'h00, 0);
    @(negedge clk); pin_i = '0;
    settle();

    // R3 / R4: outputs
    wr(8'h04, 32'h0F); wr(8'h08, 32'hAA);
    chk("R3 oe general", 32'(pin_oe), 32'h0F);
    chk("R4 out data", 32'(pin_o), 32'hAA);
    wr(8'h00, 32'h1);
    chk("R3 oe irq mode", 32'(pin_oe), 32'h0E);
    wr(8'h04, 0);

    // R6 rising edge on pin 3
    wr(8'h00, 32'h8); wr(8'h24, 32'h8); wr(8'h1C, 32'h8);
    @(negedge clk); pin_i[3] = 1'b1; settle();
    rd(8'h10, v); chk("R6 rise sets", v, 32'h8);
    chk("R10 irq edge", 32'(irq_o), 1);
    @(negedge clk); pin_i[3] = 1'b0; settle();
    rd(8'h10, v); chk("R6 held", v, 32'h8);
    wr(8'h14, ~32'h8);
    rd(8'h10, v); chk("R8 zero no effect", v, 32'h8);
    wr(8'h14, 32'h8);
    rd(8'h10, v); chk("R8 cleared", v, 0);
    chk("R10 irq off", 32'(irq_o), 0);

    // R6 falling edge on pin 4 with polarity 1
    wr(8'h00, 32'h10); wr(8'h24, 32'h10); wr(8'h20, 32'h10);
    @(negedge clk); pin_i[4] = 1'b1; settle();
    rd(8'h10, v); chk("R6 rise ignored", v, 0);
    @(negedge clk); pin_i[4] = 1'b0; settle();
    rd(8'h10, v); chk("R6 fall sets", v, 32'h10);
    wr(8'h14, 32'h10); wr(8'h20, 0);

    // R7 both edges on pin 5
    wr(8'h00, 32'h20); wr(8'h24, 32'h20); wr(8'h4C, 32'h20); wr(8'h1C, 32'h20);
    @(negedge clk); pin_i[5] = 1'b1; settle();
    rd(8'h10, v); chk("R7 rise", v, 32'h20);
    wr(8'h14, 32'h20);
    @(negedge clk); pin_i[5] = 1'b0; settle();
    rd(8'h10, v); chk("R7 fall", v, 32'h20);

    // R12: new edge latches on the same edge a clear is written
    @(negedge clk); pin_i[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wen = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h20;
    @(posedge clk); #1; reg_wen = 1'b0;
    rd(8'h10, v); chk("R12 set beats clear", v, 32'h20);

    // R9: masking
    rd(8'h18, v); chk("R9 enables", v, 32'h29);
    wr(8'h18, ~32'h20);
    rd(8'h18, v); chk("R9 mask zeros", v, 32'h09);
    chk("R10 masked", 32'(irq_o), 0);
    wr(8'h1C, 32'h0);
    rd(8'h18, v); chk("R9 unmask zeros", v, 32'h09);
    wr(8'h1C, 32'h20);
    chk("R10 unmasked", 32'(irq_o), 1);
    wr(8'h14, 32'h20);
    rd(8'h10, v); chk("R8 final clear", v, 0);

    // R1: register map
    wr(8'h04, 32'hA5A5_0000); rd(8'h04, v); chk("R1 dir", v, 32'hA5A5_0000);
    wr(8'h28, 32'h1234); rd(8'h28, v); chk("R1 filt", v, 32'h1234);
    rd(8'h4C, v); chk("R1 both", v, 32'h20);
    rd(8'h24, v); chk("R1 edge", v, 32'h20);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, v); chk("R1 pending read-only", v, 0);
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R1 input read-only", v, 32'h20);
    rd(8'h14, v); chk("R1 clear reads zero", v, 0);
    rd(8'h2C, v); chk("R1 unmapped", v, 0);

    finish_run();
  end
endmodule